// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block is the control-flow part of a small 8-bit controller core. It holds the 10-bit program counter. Each cycle it takes one decoded flow-control operation and decides the next instruction address. The operation comes with a condition code, a 10-bit target and the current carry and zero flags from the ALU. The block supports plain advance, jumps, subroutine calls, returns, two interrupt-return forms, and instructions that enable or disable interrupts. Return addresses live in a 31-entry hardware stack with a wrapping top-of-stack pointer.

Interrupts are checked at every instruction boundary. When interrupts are enabled and the request line is high, the operation presented in that cycle is discarded. Its address is pushed, the counter moves to the last address of the program space, and the enable is cleared. The carry and zero flags are preserved, and an acknowledge is raised for one cycle. An interrupt return pops that address unchanged and sets the enable according to its variant. It also presents the preserved flags with a one-cycle restore pulse, so the flag register outside the block can reload them.

Top module: `prog_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `pc_out` = 0, `int_enable` = 0, `irq_ack` = 0, `flag_restore` = 0, and an empty stack.
- R2: Operation code 0 (advance) sets `pc_out` to `pc_out`+1 modulo 1024, so 0x3FF is followed by 0x000.
- R3: Operation code 1 (jump) loads `op_target` when its condition holds and otherwise advances by one. The condition codes are: 0 always, 4 zero set, 5 zero clear, 6 carry set, 7 carry clear. Codes 1 to 3 are never satisfied.
- R4: Operation code 2 (call) uses the same conditions. When taken, it pushes the current `pc_out` and loads `op_target`. When not taken, it advances by one.
- R5: Operation code 3 (return) uses the same conditions. When taken, it pops the top entry and continues at that entry plus one. When not taken, it advances by one.
- R6: Operation codes 4 (interrupt return, enable) and 7 (interrupt return, disable) pop the top entry and continue at that exact address. They set `int_enable` to 1 for code 4 and to 0 for code 7. In the next cycle `flag_restore` is 1 for one cycle, with `flag_c_out`/`flag_z_out` equal to the flags saved when the interrupt was taken.
- R7: Operation code 5 sets `int_enable` to 1 and code 6 clears it. Both advance the counter by one.
- R8: If `int_enable` is 1 and `irq_req` is 1 at an edge, the presented operation is ignored. The current `pc_out` is pushed, `pc_out` becomes 0x3FF, `int_enable` becomes 0, and the carry and zero flags are saved. `irq_ack` is 1 for exactly the following cycle.
- R9: With `int_enable` at 0, `irq_req` has no effect: the operation executes normally and `irq_ack` stays 0.
- R10: The stack holds 31 return addresses. The 32nd unreturned push silently overwrites the oldest entry, so the 32nd pop returns the value of the 32nd push again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 4 | Decoded flow operation for the current address |
| op_cond | input | 3 | Condition code for jump, call and return |
| op_target | input | 10 | Destination for jump and call |
| flag_c_in | input | 1 | Current carry flag |
| flag_z_in | input | 1 | Current zero flag |
| irq_req | input | 1 | Interrupt request |
| pc_out | output | 10 | Instruction address |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| int_enable | output | 1 | Interrupt enable state |
| flag_restore | output | 1 | Pulse: reload flags from the two outputs below |
| flag_c_out | output | 1 | Preserved carry flag |
| flag_z_out | output | 1 | Preserved zero flag |

## Verification
A corrupted stack slot or pointer stays hidden until the matching return. It then shows as a wrong `pc_out` one cycle after that return. This is why the bench checks nested calls and fully unwinds a wrapped stack. A wrong condition decode or enable bit shows at `pc_out`, `int_enable` or `irq_ack` on the very next edge. The bench therefore sweeps every condition code against all four flag combinations and compares each cycle with an arithmetic model. Bad preserved flags show only at the restore pulse after an interrupt return. So the bench takes interrupts with distinct flag values and checks them there.

// File: rtl/seq_pkg.sv
// Package: shared operation encoding and sizes for the program sequencer.
// Assumes the decoder outside supplies one of these codes every cycle.
package seq_pkg;
    localparam int ADDR_W      = 10;
    localparam int STACK_DEPTH = 31;

    typedef enum logic [3:0] {
        OP_ADV      = 4'd0,
        OP_JUMP     = 4'd1,
        OP_CALL     = 4'd2,
        OP_RET      = 4'd3,
        OP_RETI_EN  = 4'd4,
        OP_INT_ON   = 4'd5,
        OP_INT_OFF  = 4'd6,
        OP_RETI_DIS = 4'd7
    } seq_op_e;

    localparam logic [2:0] CC_ALWAYS = 3'd0;
    localparam logic [2:0] CC_ZSET   = 3'd4;
    localparam logic [2:0] CC_ZCLR   = 3'd5;
    localparam logic [2:0] CC_CSET   = 3'd6;
    localparam logic [2:0] CC_CCLR   = 3'd7;
endpackage

// File: rtl/seq_cond_eval.sv
// Module: evaluates a 3-bit branch condition against the carry and zero flags.
// Assumes codes 1..3 are reserved and must never be satisfied.
module seq_cond_eval (
    input  logic [2:0] cond,
    input  logic       flag_c,
    input  logic       flag_z,
    output logic       hit
);
    import seq_pkg::*;

    // Purpose: map condition code and flags to a taken/not-taken decision.
    always_comb begin
        unique case (cond)
            CC_ALWAYS: hit = 1'b1;
            CC_ZSET:   hit = flag_z;
            CC_ZCLR:   hit = ~flag_z;
            CC_CSET:   hit = flag_c;
            CC_CCLR:   hit = ~flag_c;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq_ret_stack.sv
// Module: return-address stack with a wrapping top-of-stack pointer.
// Assumes push and pop never occur together; the top entry is readable
// combinationally. Overflow and underflow wrap without any indication.
module seq_ret_stack #(
    parameter int DEPTH = 31,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data
);
    localparam int             PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0]  LAST = PW'(DEPTH - 1);

    logic [PW-1:0] tos;
    logic [PW-1:0] tos_up;
    logic [PW-1:0] tos_dn;
    logic [AW-1:0] rd_slot [DEPTH];

    // Purpose: neighbouring pointer values with modular wrap.
    always_comb begin
        tos_up = (tos == LAST) ? '0 : tos + 1'b1;
        tos_dn = (tos == '0) ? LAST : tos - 1'b1;
    end

    // Purpose: move the pointer on push or pop; empty is slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tos <= '0;
        else if (push)
            tos <= tos_up;
        else if (pop)
            tos <= tos_dn;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [AW-1:0] q;
        // Purpose: write this slot when the incremented pointer selects it.
        always_ff @(posedge clk) begin
            if (push && (tos_up == PW'(i)))
                q <= push_data;
        end
        assign rd_slot[i] = q;
    end

    assign top_data = rd_slot[tos];

    AST_TOS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tos <= LAST);                                         // R10
    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));                                      // R10
    AST_PUSH_THEN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top_data == $past(push_data)));             // R10
endmodule

// File: rtl/seq_int_ctrl.sv
// Module: interrupt enable, flag preservation, acknowledge and restore pulse.
// Assumes the take decision overrides every operation in the same cycle.
module seq_int_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic do_on,
    input  logic do_off,
    input  logic do_reti_en,
    input  logic do_reti_dis,
    input  logic flag_c_in,
    input  logic flag_z_in,
    output logic take,
    output logic int_en,
    output logic ack,
    output logic restore,
    output logic keep_c,
    output logic keep_z
);
    assign take = int_en & irq_req;

    // Purpose: update enable, preserved flags and the two one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en  <= 1'b0;
            ack     <= 1'b0;
            restore <= 1'b0;
            keep_c  <= 1'b0;
            keep_z  <= 1'b0;
        end else begin
            ack     <= take;
            restore <= ~take & (do_reti_en | do_reti_dis);
            if (take) begin
                int_en <= 1'b0;
                keep_c <= flag_c_in;
                keep_z <= flag_z_in;
            end else if (do_on || do_reti_en) begin
                int_en <= 1'b1;
            end else if (do_off || do_reti_dis) begin
                int_en <= 1'b0;
            end
        end
    end

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);                                        // R8
    AST_ACK_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !int_en);                                     // R8
    AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> !ack);                                    // R9
    AST_RETI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (do_reti_en && !take) |=> (restore && int_en));       // R6
endmodule

// File: rtl/prog_sequencer.sv
// Module: program counter and flow-control unit with return stack and
// interrupt entry. One operation is consumed per clock; pc_out is registered.
// Assumes op_code/op_cond/op_target describe the instruction at pc_out.
module prog_sequencer #(
    parameter int ADDR_W      = seq_pkg::ADDR_W,
    parameter int STACK_DEPTH = seq_pkg::STACK_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_code,
    input  logic [2:0]        op_cond,
    input  logic [ADDR_W-1:0] op_target,
    input  logic              flag_c_in,
    input  logic              flag_z_in,
    input  logic              irq_req,
    output logic [ADDR_W-1:0] pc_out,
    output logic              irq_ack,
    output logic              int_enable,
    output logic              flag_restore,
    output logic              flag_c_out,
    output logic              flag_z_out
);
    import seq_pkg::*;

    localparam logic [ADDR_W-1:0] IRQ_VEC = '1;
    localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);

    seq_op_e           op;
    logic              hit;
    logic              take;
    logic              push;
    logic              pop;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] pc_nxt;
    logic [ADDR_W-1:0] top;

    assign op = seq_op_e'(op_code);

    seq_cond_eval u_cond (
        .cond   (op_cond),
        .flag_c (flag_c_in),
        .flag_z (flag_z_in),
        .hit    (hit)
    );

    seq_ret_stack #(.DEPTH(STACK_DEPTH), .AW(ADDR_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (pc),
        .top_data  (top)
    );

    seq_int_ctrl u_int (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .do_on       (op == OP_INT_ON),
        .do_off      (op == OP_INT_OFF),
        .do_reti_en  (op == OP_RETI_EN),
        .do_reti_dis (op == OP_RETI_DIS),
        .flag_c_in   (flag_c_in),
        .flag_z_in   (flag_z_in),
        .take        (take),
        .int_en      (int_enable),
        .ack         (irq_ack),
        .restore     (flag_restore),
        .keep_c      (flag_c_out),
        .keep_z      (flag_z_out)
    );

    // Purpose: choose the next address and the stack action for this cycle.
    always_comb begin
        pc_nxt = pc + ONE;
        push   = 1'b0;
        pop    = 1'b0;
        if (take) begin
            push   = 1'b1;
            pc_nxt = IRQ_VEC;
        end else begin
            unique case (op)
                OP_JUMP: if (hit) pc_nxt = op_target;
                OP_CALL: if (hit) begin
                    push   = 1'b1;
                    pc_nxt = op_target;
                end
                OP_RET: if (hit) begin
                    pop    = 1'b1;
                    pc_nxt = top + ONE;
                end
                OP_RETI_EN, OP_RETI_DIS: begin
                    pop    = 1'b1;
                    pc_nxt = top;
                end
                default: ;
            endcase
        end
    end

    // Purpose: program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else
            pc <= pc_nxt;
    end

    assign pc_out = pc;

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADV && !take) |=> (pc_out == $past(pc_out) + ONE));   // R2
    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JUMP && hit && !take) |=> (pc_out == $past(op_target))); // R3
    AST_CALL_NO_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL && !hit && !take) |=> (pc_out == $past(pc_out) + ONE)); // R4
    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (pc_out == IRQ_VEC));                               // R8
    AST_RET_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RET && hit && !take) |=> (pc_out == $past(top) + ONE)); // R5
endmodule

// File: tb/prog_sequencer_test.sv
module prog_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [2:0] op_cond = 3'd0;
    logic [9:0] op_target = 10'd0;
    logic       flag_c_in = 1'b0;
    logic       flag_z_in = 1'b0;
    logic       irq_req = 1'b0;
    logic [9:0] pc_out;
    logic       irq_ack, int_enable, flag_restore, flag_c_out, flag_z_out;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural model state
    logic [9:0] m_pc = 10'd0;
    logic       m_ie = 1'b0;
    logic       m_kc = 1'b0;
    logic       m_kz = 1'b0;
    logic [9:0] m_stk [31];
    int         m_tos = 0;

    prog_sequencer uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_cond(op_cond),
        .op_target(op_target), .flag_c_in(flag_c_in), .flag_z_in(flag_z_in),
        .irq_req(irq_req), .pc_out(pc_out), .irq_ack(irq_ack),
        .int_enable(int_enable), .flag_restore(flag_restore),
        .flag_c_out(flag_c_out), .flag_z_out(flag_z_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit cond_ok(input logic [2:0] cd, input logic c, input logic z);
        case (cd)
            3'd0: return 1'b1;
            3'd4: return z;
            3'd5: return !z;
            3'd6: return c;
            3'd7: return !c;
            default: return 1'b0;
        endcase
    endfunction

    task automatic m_push(input logic [9:0] v);
        m_tos = (m_tos + 1) % 31;
        m_stk[m_tos] = v;
    endtask

    task automatic m_pop();
        m_tos = (m_tos == 0) ? 30 : m_tos - 1;
    endtask

    // drive one operation, advance the model, check after the edge
    task automatic apply(input logic [3:0] op, input logic [2:0] cd,
                         input logic [9:0] tg, input logic c, input logic z,
                         input logic irq, input string req);
        logic [9:0] npc;
        bit         tk, rs;
        op_code = op; op_cond = cd; op_target = tg;
        flag_c_in = c; flag_z_in = z; irq_req = irq;
        tk  = m_ie && irq;
        rs  = 1'b0;
        npc = m_pc + 10'd1;
        if (tk) begin
            m_push(m_pc); npc = 10'h3FF; m_ie = 1'b0; m_kc = c; m_kz = z;
        end else begin
            case (op)
                4'd1: if (cond_ok(cd, c, z)) npc = tg;
                4'd2: if (cond_ok(cd, c, z)) begin m_push(m_pc); npc = tg; end
                4'd3: if (cond_ok(cd, c, z)) begin npc = m_stk[m_tos] + 10'd1; m_pop(); end
                4'd4, 4'd7: begin
                    npc = m_stk[m_tos]; m_pop(); m_ie = (op == 4'd4); rs = 1'b1;
                end
                4'd5: m_ie = 1'b1;
                4'd6: m_ie = 1'b0;
                default: ;
            endcase
        end
        @(posedge clk);
        #2;
        m_pc = npc;
        chk(pc_out == m_pc, req, pc_out, m_pc);
        chk(irq_ack == tk, {req, " ack"}, irq_ack, tk);
        chk(int_enable == m_ie, {req, " enable"}, int_enable, m_ie);
        chk(flag_restore == rs, {req, " restore"}, flag_restore, rs);
        if (rs) begin
            chk(flag_c_out == m_kc, "R6 carry", flag_c_out, m_kc);
            chk(flag_z_out == m_kz, "R6 zero", flag_z_out, m_kz);
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk(pc_out == 10'd0, "R1 pc", pc_out, 0);
        chk(int_enable == 1'b0, "R1 enable", int_enable, 0);
        chk(irq_ack == 1'b0, "R1 ack", irq_ack, 0);
        chk(flag_restore == 1'b0, "R1 restore", flag_restore, 0);
        rst_n = 1'b1;

        // R2 plain advance
        for (int i = 0; i < 3; i++) apply(4'd0, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R2");

        // R3 every condition against every flag pair
        for (int cd = 0; cd < 8; cd++)
            for (int f = 0; f < 4; f++)
                apply(4'd1, 3'(cd), 10'((cd * 37 + f * 5 + 100) % 1024), f[1], f[0], 1'b0, "R3");

        // R4 conditional calls, each unwound by an unconditional return
        for (int cd = 0; cd < 8; cd++)
            for (int f = 0; f < 4; f++) begin
                apply(4'd2, 3'(cd), 10'(300 + cd * 8 + f), f[1], f[0], 1'b0, "R4");
                if (cond_ok(3'(cd), f[1], f[0]))
                    apply(4'd3, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R5");
            end

        // R5 conditional returns
        for (int cd = 0; cd < 8; cd++)
            for (int f = 0; f < 4; f++) begin
                apply(4'd2, 3'd0, 10'(500 + cd * 4 + f), 1'b0, 1'b0, 1'b0, "R4");
                apply(4'd3, 3'(cd), 10'd0, f[1], f[0], 1'b0, "R5");
                if (!cond_ok(3'(cd), f[1], f[0]))
                    apply(4'd3, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R5");
            end

        // R4 R5 nesting five deep
        for (int i = 0; i < 5; i++) apply(4'd2, 3'd0, 10'(600 + 20 * i), 1'b0, 1'b0, 1'b0, "R4 nest");
        for (int i = 0; i < 5; i++) apply(4'd3, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R5 nest");

        // R9 request while disabled
        apply(4'd0, 3'd0, 10'd0, 1'b0, 1'b0, 1'b1, "R9");
        apply(4'd1, 3'd0, 10'h123, 1'b0, 1'b0, 1'b1, "R9");

        // R7 enable, disable, enable
        apply(4'd5, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R7");
        apply(4'd6, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R7");
        apply(4'd5, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R7");

        // R8 interrupt inside a subroutine, jump discarded; R2 wrap at vector
        apply(4'd2, 3'd0, 10'h200, 1'b0, 1'b0, 1'b0, "R4");
        apply(4'd0, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R2");
        apply(4'd1, 3'd0, 10'h0AA, 1'b1, 1'b0, 1'b1, "R8");
        apply(4'd0, 3'd0, 10'd0, 1'b0, 1'b1, 1'b1, "R8 held");
        apply(4'd0, 3'd0, 10'd0, 1'b0, 1'b1, 1'b0, "R2 wrap");
        apply(4'd4, 3'd0, 10'd0, 1'b0, 1'b1, 1'b0, "R6");
        apply(4'd0, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R6");
        // second entry, leave with interrupts disabled, other flag pair
        apply(4'd1, 3'd0, 10'h050, 1'b0, 1'b1, 1'b1, "R8");
        apply(4'd7, 3'd0, 10'd0, 1'b1, 1'b0, 1'b0, "R6");
        apply(4'd0, 3'd0, 10'd0, 1'b0, 1'b0, 1'b1, "R9");
        apply(4'd3, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R5");

        // R10 overflow: 32 pushes then 32 pops
        for (int i = 0; i < 32; i++) apply(4'd2, 3'd0, 10'(700 + i), 1'b0, 1'b0, 1'b0, "R10 push");
        for (int i = 0; i < 32; i++) apply(4'd3, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R10 pop");

        // R1 reset mid-run
        apply(4'd5, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R7");
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        chk(pc_out == 10'd0, "R1 pc again", pc_out, 0);
        chk(int_enable == 1'b0, "R1 enable again", int_enable, 0);
        m_pc = 10'd0; m_ie = 1'b0; m_tos = 0;
        apply(4'd0, 3'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule